// File: doc/BRIEF.md
# Multicarrier Transmit Symbol Framer

This block wraps the inverse transform on the transmit side of a discrete multitone modem. On the way in, it collects one complex subsymbol per carrier from the constellation mapper, N/2 of them, and replays them as an N-bin spectrum with Hermitian symmetry. The upper half of the spectrum holds the conjugates of the lower half, so the inverse transform returns a purely real symbol. On the way out, it collects the N real time-domain samples that the transform returns. It then emits a frame that starts with a cyclic prefix, the last v samples of the symbol, and carries the whole symbol after it.

Two sizings exist. Downstream uses N = 512 with a 32-sample prefix, and upstream uses N = 64 with a 4-sample prefix. A plain `mode` pin picks the sizing. Each half of the block samples `mode` when it accepts the first item of a symbol and keeps that sizing until the symbol is finished. A change on the pin therefore only takes effect at a symbol boundary.

All four data interfaces are valid/ready streams. A transfer happens on a rising clock edge where both valid and ready are high. An output that shows valid keeps its data and flags unchanged until it is accepted, and it does not depend on ready. Each half works in two phases: it fills its buffer, then drains it. While a half is draining, its input ready is low, so the upstream source is held back. While a half is filling, its output valid is low.

Top module: `dmt_framer`

## Requirements
- R1: After reset, `sub_ready` and `td_ready` are 1, and `bin_valid` and `fr_valid` are 0.
- R2: `mode` 0 selects N = 512, v = 32 and `mode` 1 selects N = 64, v = 4. Each half samples `mode` on the edge that accepts the first item of a symbol. A change on `mode` later in that symbol has no effect on that symbol's length or content.
- R3: The spectrum side accepts exactly N/2 subsymbols, carriers 0 to N/2-1 in order. It then emits N bins in index order 0 to N-1, with `bin_last` high only on bin N-1. `sub_ready` is 0 while bins are pending.
- R4: For 1 <= k <= N/2-1, bin k equals subsymbol k, with both the real and imaginary parts passed unchanged.
- R5: For 1 <= k <= N/2-1, bin N-k has the real part of subsymbol k and the two's-complement negation of its imaginary part, wrapping at the DW-bit width (-32768 maps to -32768).
- R6: Bin 0 carries the real part of subsymbol 0 and an imaginary part of 0. Bin N/2 is 0 in both parts.
- R7: The frame side accepts exactly N samples. It then emits N+v samples: symbol samples N-v to N-1 first, then samples 0 to N-1.
- R8: `fr_sof` is high only on the first output sample of a frame, and `fr_eof` only on the last (sample N+v-1).
- R9: When `bin_valid` or `fr_valid` is high and the matching ready is low, the next cycle shows the same valid, data and flags.
- R10: `td_ready` is 0 while any frame sample is pending output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | Sizing select: 0 = N 512 / v 32, 1 = N 64 / v 4 |
| sub_valid | input | 1 | Subsymbol offered |
| sub_ready | output | 1 | Spectrum side can take a subsymbol |
| sub_re | input | DW | Subsymbol real part, signed |
| sub_im | input | DW | Subsymbol imaginary part, signed |
| bin_valid | output | 1 | Spectrum bin offered to the inverse transform |
| bin_ready | input | 1 | Inverse transform takes the bin |
| bin_re | output | DW | Bin real part |
| bin_im | output | DW | Bin imaginary part |
| bin_last | output | 1 | Bin N-1 of the spectrum |
| td_valid | input | 1 | Time-domain sample offered by the inverse transform |
| td_ready | output | 1 | Frame side can take a sample |
| td_data | input | DW | Real time-domain sample |
| fr_valid | output | 1 | Frame sample offered to the converter path |
| fr_ready | input | 1 | Converter path takes the sample |
| fr_data | output | DW | Frame sample |
| fr_sof | output | 1 | First sample of the frame (first prefix sample) |
| fr_eof | output | 1 | Last sample of the frame |

## Verification
The bench goes after the mirror addressing. If the design got the conjugate index off by one, or took it modulo the wrong N in the short sizing, the upper-half bins would hold the wrong carrier. A design that negated the real part instead of the imaginary part would also be caught. One subsymbol carries an imaginary part of -32768, so a saturating negation is visible. The bench checks that bin 0 and bin N/2 come out real; a design that passed the DC imaginary part through, or put data on the Nyquist bin, would fail there. The bench flips `mode` right after the first item of a symbol on both sides. A design that kept following the pin would end the symbol at the wrong length and misplace `bin_last` or `fr_eof`. The bench also drops ready at intervals and checks that stalled outputs hold steady. It checks that the frame opens with the tail of the symbol rather than the head, and that the prefix length follows the sizing.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic {
    MODE_DOWN = 1'b0,
    MODE_UP   = 1'b1
  } dmt_mode_e;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } dmt_phase_e;
endpackage

// File: rtl/dmt_ram.sv
module dmt_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dmt_mirror.sv
module dmt_mirror
  import dmt_pkg::*;
#(
  parameter int DW        = 16,
  parameter int N_DN_LOG2 = 9,
  parameter int N_UP_LOG2 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          out_last
);
  localparam int NDN = 2 ** N_DN_LOG2;
  localparam int NUP = 2 ** N_UP_LOG2;
  localparam int HDN = NDN / 2;
  localparam int HUP = NUP / 2;
  localparam int HAW = N_DN_LOG2 - 1;
  localparam int BAW = N_DN_LOG2;

  dmt_phase_e     phase;
  logic [HAW-1:0] wcnt;
  logic [BAW-1:0] bcnt;
  dmt_mode_e      mode_q, mode_now;
  logic [HAW-1:0] half_m1, raddr;
  logic [BAW-1:0] half_b, n_m1;
  logic [BAW:0]   n_full;
  logic [2*DW-1:0] rdata;
  logic [DW-1:0]  rd_re, rd_im;

  // the sizing follows the pin until the first subsymbol is taken
  assign mode_now = (phase == PH_FILL && wcnt == '0) ? dmt_mode_e'(mode) : mode_q;
  assign half_m1  = (mode_now == MODE_UP) ? HAW'(HUP - 1) : HAW'(HDN - 1);
  assign half_b   = (mode_now == MODE_UP) ? BAW'(HUP)     : BAW'(HDN);
  assign n_m1     = (mode_now == MODE_UP) ? BAW'(NUP - 1) : BAW'(NDN - 1);
  assign n_full   = (mode_now == MODE_UP) ? (BAW+1)'(NUP) : (BAW+1)'(NDN);

  assign in_ready  = (phase == PH_FILL);
  assign out_valid = (phase == PH_DRAIN);
  assign out_last  = out_valid && (bcnt == n_m1);

  // upper half reads carrier N-k
  assign raddr = (bcnt < half_b) ? HAW'(bcnt) : HAW'(n_full - {1'b0, bcnt});

  dmt_ram #(.W(2*DW), .DEPTH(HDN)) u_carriers (
    .clk   (clk),
    .we    (in_valid && in_ready),
    .waddr (wcnt),
    .wdata ({in_re, in_im}),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign rd_re = rdata[2*DW-1:DW];
  assign rd_im = rdata[DW-1:0];

  always_comb begin
    if (bcnt == '0) begin
      out_re = rd_re;
      out_im = '0;
    end else if (bcnt == half_b) begin
      out_re = '0;
      out_im = '0;
    end else if (bcnt < half_b) begin
      out_re = rd_re;
      out_im = rd_im;
    end else begin
      out_re = rd_re;
      out_im = ~rd_im + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FILL;
      wcnt   <= '0;
      bcnt   <= '0;
      mode_q <= MODE_DOWN;
    end else if (phase == PH_FILL) begin
      if (wcnt == '0) mode_q <= dmt_mode_e'(mode);
      if (in_valid) begin
        if (wcnt == half_m1) begin
          wcnt  <= '0;
          bcnt  <= '0;
          phase <= PH_DRAIN;
        end else begin
          wcnt <= wcnt + HAW'(1);
        end
      end
    end else if (out_ready) begin
      if (bcnt == n_m1) begin
        bcnt  <= '0;
        phase <= PH_FILL;
      end else begin
        bcnt <= bcnt + BAW'(1);
      end
    end
  end
endmodule

// File: rtl/dmt_prefix.sv
module dmt_prefix
  import dmt_pkg::*;
#(
  parameter int DW        = 16,
  parameter int N_DN_LOG2 = 9,
  parameter int CP_DN     = 32,
  parameter int N_UP_LOG2 = 6,
  parameter int CP_UP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof
);
  localparam int NDN = 2 ** N_DN_LOG2;
  localparam int NUP = 2 ** N_UP_LOG2;
  localparam int AW  = N_DN_LOG2;
  localparam int OCW = N_DN_LOG2 + 1;

  dmt_phase_e     phase;
  logic [AW-1:0]  wcnt, n_m1, raddr;
  logic [OCW-1:0] ocnt, n_full, cp_len, o_last;
  dmt_mode_e      mode_q, mode_now;

  assign mode_now = (phase == PH_FILL && wcnt == '0) ? dmt_mode_e'(mode) : mode_q;
  assign n_full   = (mode_now == MODE_UP) ? OCW'(NUP)   : OCW'(NDN);
  assign cp_len   = (mode_now == MODE_UP) ? OCW'(CP_UP) : OCW'(CP_DN);
  assign n_m1     = (mode_now == MODE_UP) ? AW'(NUP - 1) : AW'(NDN - 1);
  assign o_last   = n_full + cp_len - OCW'(1);

  assign in_ready  = (phase == PH_FILL);
  assign out_valid = (phase == PH_DRAIN);
  assign out_sof   = out_valid && (ocnt == '0);
  assign out_eof   = out_valid && (ocnt == o_last);

  // prefix replays the tail, then the symbol from its start
  assign raddr = (ocnt < cp_len) ? AW'(n_full - cp_len + ocnt) : AW'(ocnt - cp_len);

  dmt_ram #(.W(DW), .DEPTH(NDN)) u_symbol (
    .clk   (clk),
    .we    (in_valid && in_ready),
    .waddr (wcnt),
    .wdata (in_data),
    .raddr (raddr),
    .rdata (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FILL;
      wcnt   <= '0;
      ocnt   <= '0;
      mode_q <= MODE_DOWN;
    end else if (phase == PH_FILL) begin
      if (wcnt == '0) mode_q <= dmt_mode_e'(mode);
      if (in_valid) begin
        if (wcnt == n_m1) begin
          wcnt  <= '0;
          ocnt  <= '0;
          phase <= PH_DRAIN;
        end else begin
          wcnt <= wcnt + AW'(1);
        end
      end
    end else if (out_ready) begin
      if (ocnt == o_last) begin
        ocnt  <= '0;
        phase <= PH_FILL;
      end else begin
        ocnt <= ocnt + OCW'(1);
      end
    end
  end
endmodule

// File: rtl/dmt_framer.sv
module dmt_framer #(
  parameter int DW        = 16,
  parameter int N_DN_LOG2 = 9,
  parameter int CP_DN     = 32,
  parameter int N_UP_LOG2 = 6,
  parameter int CP_UP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          sub_valid,
  output logic          sub_ready,
  input  logic [DW-1:0] sub_re,
  input  logic [DW-1:0] sub_im,
  output logic          bin_valid,
  input  logic          bin_ready,
  output logic [DW-1:0] bin_re,
  output logic [DW-1:0] bin_im,
  output logic          bin_last,
  input  logic          td_valid,
  output logic          td_ready,
  input  logic [DW-1:0] td_data,
  output logic          fr_valid,
  input  logic          fr_ready,
  output logic [DW-1:0] fr_data,
  output logic          fr_sof,
  output logic          fr_eof
);
  dmt_mirror #(.DW(DW), .N_DN_LOG2(N_DN_LOG2), .N_UP_LOG2(N_UP_LOG2)) u_mirror (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .in_valid  (sub_valid),
    .in_ready  (sub_ready),
    .in_re     (sub_re),
    .in_im     (sub_im),
    .out_valid (bin_valid),
    .out_ready (bin_ready),
    .out_re    (bin_re),
    .out_im    (bin_im),
    .out_last  (bin_last)
  );

  dmt_prefix #(.DW(DW), .N_DN_LOG2(N_DN_LOG2), .CP_DN(CP_DN),
               .N_UP_LOG2(N_UP_LOG2), .CP_UP(CP_UP)) u_prefix (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .in_valid  (td_valid),
    .in_ready  (td_ready),
    .in_data   (td_data),
    .out_valid (fr_valid),
    .out_ready (fr_ready),
    .out_data  (fr_data),
    .out_sof   (fr_sof),
    .out_eof   (fr_eof)
  );
endmodule

// File: rtl/dmt_framer_chk.sv
module dmt_framer_chk #(
  parameter int DW        = 16,
  parameter int N_DN_LOG2 = 9,
  parameter int CP_DN     = 32,
  parameter int N_UP_LOG2 = 6,
  parameter int CP_UP     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sub_ready,
  input logic          bin_valid,
  input logic          bin_ready,
  input logic [DW-1:0] bin_re,
  input logic [DW-1:0] bin_im,
  input logic          bin_last,
  input logic          td_ready,
  input logic          fr_valid,
  input logic          fr_ready,
  input logic [DW-1:0] fr_data,
  input logic          fr_sof,
  input logic          fr_eof
);
  localparam int NDN = 2 ** N_DN_LOG2;
  localparam int NUP = 2 ** N_UP_LOG2;
  localparam int CW  = N_DN_LOG2 + 2;

  logic [CW-1:0] bcnt, fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      fcnt <= '0;
    end else begin
      if (bin_valid && bin_ready) bcnt <= bin_last ? '0 : bcnt + CW'(1);
      if (fr_valid && fr_ready)   fcnt <= fr_eof ? '0 : fcnt + CW'(1);
    end
  end

  // R9
  bin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid && !bin_ready |=> bin_valid && $stable(bin_re) && $stable(bin_im) && $stable(bin_last));

  // R9
  fr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && !fr_ready |=> fr_valid && $stable(fr_data) && $stable(fr_sof) && $stable(fr_eof));

  // R3
  bin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid |-> !sub_ready);

  // R10
  fr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid |-> !td_ready);

  // R3
  bin_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid && bin_last |-> (bcnt == CW'(NDN - 1) || bcnt == CW'(NUP - 1)));

  // R6
  dc_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid && bcnt == '0 |-> bin_im == '0);

  // R8
  sof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && fr_sof |-> fcnt == '0);

  // R8
  eof_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && fr_eof |-> (fcnt == CW'(NDN + CP_DN - 1) || fcnt == CW'(NUP + CP_UP - 1)));
endmodule

bind dmt_framer dmt_framer_chk #(
  .DW(DW), .N_DN_LOG2(N_DN_LOG2), .CP_DN(CP_DN), .N_UP_LOG2(N_UP_LOG2), .CP_UP(CP_UP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sub_ready (sub_ready),
  .bin_valid (bin_valid),
  .bin_ready (bin_ready),
  .bin_re    (bin_re),
  .bin_im    (bin_im),
  .bin_last  (bin_last),
  .td_ready  (td_ready),
  .fr_valid  (fr_valid),
  .fr_ready  (fr_ready),
  .fr_data   (fr_data),
  .fr_sof    (fr_sof),
  .fr_eof    (fr_eof)
);

// File: tb/tb_dmt_framer.sv
module tb_dmt_framer;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic sub_valid = 1'b0, sub_ready;
  logic [DW-1:0] sub_re = '0, sub_im = '0;
  logic bin_valid, bin_ready = 1'b0, bin_last;
  logic [DW-1:0] bin_re, bin_im;
  logic td_valid = 1'b0, td_ready;
  logic [DW-1:0] td_data = '0;
  logic fr_valid, fr_ready = 1'b0, fr_sof, fr_eof;
  logic [DW-1:0] fr_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dmt_framer dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nsz(input bit md);
    return md ? 64 : 512;
  endfunction
  function automatic int cpsz(input bit md);
    return md ? 4 : 32;
  endfunction
  function automatic logic [DW-1:0] sre(input int k, input int seed);
    return DW'(k * 3 + seed + 100);
  endfunction
  function automatic logic [DW-1:0] sim(input int k, input int seed);
    return (k == 5) ? 16'h8000 : DW'(seed * 5 - k * 11);
  endfunction
  function automatic logic [DW-1:0] tval(input int i, input int seed);
    return DW'(i * 37 + seed * 3 + 1);
  endfunction

  // expected {re, im, last} of bin b
  function automatic logic [32:0] exp_bin(input bit md, input int seed, input int b);
    int n = nsz(md);
    int h = n / 2;
    logic [DW-1:0] im;
    logic last = (b == n - 1);
    if (b == 0) return {sre(0, seed), 16'h0, last};
    if (b == h) return {16'h0, 16'h0, last};
    if (b < h)  return {sre(b, seed), sim(b, seed), last};
    im = ~sim(n - b, seed) + 16'd1;
    return {sre(n - b, seed), im, last};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    // R1
    chk(sub_ready === 1'b1 && td_ready === 1'b1 && bin_valid === 1'b0 && fr_valid === 1'b0,
        "R1 reset state", {60'h0, sub_ready, td_ready, bin_valid, fr_valid}, 64'hC);
  endtask

  // R2 R3 R4 R5 R6 R9: load a spectrum, read it back, optionally stall and flip mode
  task automatic t_spectrum(input bit md, input int seed, input bit stall, input bit flip);
    int h = nsz(md) / 2;
    int n = nsz(md);
    int cyc = 0;
    logic held = 1'b0;
    logic [32:0] prev = '0;
    mode = md;
    for (int k = 0; k < h; ) begin
      @(negedge clk);
      if (flip && k > 0) mode = ~md;
      sub_valid = 1'b1;
      sub_re = sre(k, seed);
      sub_im = sim(k, seed);
      if (sub_ready) k++;
    end
    @(negedge clk);
    sub_valid = 1'b0;
    for (int b = 0; b < n; ) begin
      logic r;
      if (b > 0) @(negedge clk);
      cyc++;
      if (held) chk(bin_valid && {bin_re, bin_im, bin_last} == prev, "R9 bin held",
                    {31'h0, bin_re, bin_im, bin_last}, {31'h0, prev});
      r = !(stall && (cyc % 4 == 1));
      if (bin_valid) begin
        // R3 (sub_ready low while draining), R4/R5/R6 content, R2 sizing
        chk({bin_re, bin_im, bin_last} == exp_bin(md, seed, b) && !sub_ready,
            $sformatf("R3/R4/R5/R6 bin %0d mode %0d", b, md),
            {30'h0, sub_ready, bin_re, bin_im, bin_last}, {31'h0, exp_bin(md, seed, b)});
        if (r) b++;
      end
      held = bin_valid && !r;
      prev = {bin_re, bin_im, bin_last};
      bin_ready = r;
    end
    @(negedge clk);
    bin_ready = 1'b0;
    // R2: spectrum side is back to filling after exactly N bins
    chk(sub_ready && !bin_valid, "R2 R3 spectrum done", {62'h0, sub_ready, bin_valid}, 64'h2);
    mode = md;
  endtask

  // R2 R7 R8 R9 R10: load a symbol, read the frame
  task automatic t_frame(input bit md, input int seed, input bit stall, input bit flip);
    int n = nsz(md);
    int v = cpsz(md);
    int cyc = 0;
    logic held = 1'b0;
    logic [17:0] prev = '0;
    mode = md;
    for (int i = 0; i < n; ) begin
      @(negedge clk);
      if (flip && i > 0) mode = ~md;
      td_valid = 1'b1;
      td_data = tval(i, seed);
      if (td_ready) i++;
    end
    @(negedge clk);
    td_valid = 1'b0;
    for (int j = 0; j < n + v; ) begin
      logic r;
      logic [17:0] e;
      if (j > 0) @(negedge clk);
      cyc++;
      if (held) chk(fr_valid && {fr_data, fr_sof, fr_eof} == prev, "R9 frame held",
                    {46'h0, fr_data, fr_sof, fr_eof}, {46'h0, prev});
      r = !(stall && (cyc % 3 == 2));
      if (fr_valid) begin
        e = {tval((j < v) ? (n - v + j) : (j - v), seed), j == 0, j == n + v - 1};
        // R7 content, R8 markers, R10 no intake while sending
        chk({fr_data, fr_sof, fr_eof} == e && !td_ready,
            $sformatf("R7/R8/R10 frame %0d mode %0d", j, md),
            {45'h0, td_ready, fr_data, fr_sof, fr_eof}, {46'h0, e});
        if (r) j++;
      end
      held = fr_valid && !r;
      prev = {fr_data, fr_sof, fr_eof};
      fr_ready = r;
    end
    @(negedge clk);
    fr_ready = 1'b0;
    // R2: frame side back to filling after N+v samples
    chk(td_ready && !fr_valid, "R2 R7 frame done", {62'h0, td_ready, fr_valid}, 64'h2);
    mode = md;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_spectrum(1'b0, 7, 1'b0, 1'b0);
    t_spectrum(1'b1, 21, 1'b1, 1'b0);
    t_spectrum(1'b0, 3, 1'b1, 1'b1);
    t_spectrum(1'b1, 9, 1'b0, 1'b1);
    t_frame(1'b0, 5, 1'b0, 1'b0);
    t_frame(1'b1, 11, 1'b1, 1'b0);
    t_frame(1'b1, 2, 1'b1, 1'b1);
    t_frame(1'b0, 13, 1'b1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule